// File: doc/BRIEF.md
# Split-Width Memory and I/O Bus Sequencer

This block sits between a processor core and two external buses and turns each core access into the bus cycles that carry it. A core access is a byte, a 16-bit word or a 32-bit long, aimed at either the memory space or the I/O space. The memory bus is 16 bits wide and big-endian: the byte at the lower address travels in the upper half of a word. The I/O bus is 8 bits wide and little-endian: the byte at the lower address is the least significant one. A single word therefore splits into bytes in opposite orders, depending on which space it targets.

The core presents one request for one clock on `req_valid`. The sequencer latches the request and issues one bus strobe per sub-cycle. It waits for the matching ready before it moves on. When the last sub-cycle has finished, it raises `done` for exactly one clock, with the assembled read result on `rdata`. I/O accesses made with a nonzero mode code target a special space that has no bus here. For those accesses the sequencer issues no cycle, completes at once and returns zero.

Top module: `bus_split_seq`

## Requirements
- R1: A memory word or long access drives its bus addresses with bit 0 cleared. A memory byte access drives the exact requested address.
- R2: A memory long (`req_size`=2) takes two word cycles. The first cycle is at the aligned address and carries bits 31:16. The second is at the aligned address plus 2 and carries bits 15:0. Reads assemble the result the same way.
- R3: An I/O word (`req_size`=1) takes two byte cycles. The first is at the requested address, with no alignment, and carries bits 7:0. The second is at the address plus 1 and carries bits 15:8.
- R4: An I/O long takes four byte cycles at the requested address plus 0, 1, 2 and 3, in that order. Cycle k carries bits 8k+7:8k.
- R5: An I/O access whose `req_mode` is nonzero issues no bus cycle at all. A read of this kind returns zero, and a write leaves the I/O space unchanged. Memory accesses ignore `req_mode`.
- R6: Each strobe lasts one clock, and only one space is strobed at a time. The next sub-cycle is not strobed until `*_rdy` has answered the previous strobe, however many wait clocks that takes.
- R7: `done` is high for exactly one clock. That clock is the one right after the edge that sampled the last ready, and `rdata` holds the result during it. No strobe follows `done` until a new request arrives.
- R8: A request that arrives while an access is in progress is dropped. It causes no bus cycle and no `done`.
- R9: After reset, `done`, both strobes and `rdata` are all zero.
- R10: A memory byte access is one cycle with `mem_byte` high. The byte uses bits 7:0 of the memory data bus. Byte and word read results are zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request, sampled while idle |
| req_space | input | 1 | 0 selects memory, 1 selects I/O |
| req_size | input | 2 | 0 byte, 1 word, 2 long |
| req_mode | input | MODE_W | I/O mode code; nonzero selects the special space |
| req_write | input | 1 | 1 for a write |
| req_addr | input | AW | Byte address |
| req_wdata | input | CPU_DW | Write data, right-justified |
| done | output | 1 | One-clock completion pulse |
| rdata | output | CPU_DW | Assembled read data |
| mem_stb | output | 1 | Memory cycle strobe |
| mem_write | output | 1 | Memory cycle is a write |
| mem_byte | output | 1 | Memory cycle moves a single byte |
| mem_addr | output | AW | Memory cycle address |
| mem_wdata | output | MEM_DW | Memory write data |
| mem_rdata | input | MEM_DW | Memory read data, valid with ready |
| mem_rdy | input | 1 | Memory cycle complete |
| io_stb | output | 1 | I/O cycle strobe |
| io_write | output | 1 | I/O cycle is a write |
| io_addr | output | AW | I/O cycle address |
| io_wdata | output | IO_DW | I/O write byte |
| io_rdata | input | IO_DW | I/O read byte, valid with ready |
| io_rdy | input | 1 | I/O cycle complete |

## Verification
The same kind of access is sent once to memory and once to I/O. Memory and I/O words are placed at odd addresses, so a missing alignment in memory, or a spurious alignment in I/O, shows up in the logged bus addresses. Distinct byte values in every lane of longs and words expose any swapped half or byte order, in reads and in writes alike. The bench also runs accesses with zero and with several wait clocks, which separates strobe and completion timing from data handling. Special-mode I/O accesses come right after a nonzero read, so a result that was not cleared would be caught. A request injected mid-sequence shows whether the sequencer truly ignores it.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int unsigned WORD_BITS = 16;
    localparam int unsigned BYTE_BITS = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

endpackage

// File: rtl/bseq_plan.sv
// Per-beat address, width, last flag and write-data slice for one access.
module bseq_plan
    import bseq_pkg::*;
#(
    parameter int unsigned AW     = 16,
    parameter int unsigned CPU_DW = 32,
    parameter int unsigned MEM_DW = 16,
    parameter int unsigned IO_DW  = 8,
    parameter int unsigned BEAT_W = 2
) (
    input  logic [AW-1:0]     base_addr,
    input  logic [1:0]        size,
    input  logic              io_space,
    input  logic [BEAT_W-1:0] beat,
    input  logic [CPU_DW-1:0] wdata,
    output logic [AW-1:0]     mem_addr,
    output logic [AW-1:0]     io_addr,
    output logic              mem_byte,
    output logic              last,
    output logic [MEM_DW-1:0] mem_wdata,
    output logic [IO_DW-1:0]  io_wdata
);
    localparam int unsigned MEM_BYTES     = MEM_DW / BYTE_BITS;
    localparam int unsigned MEM_SHIFT     = $clog2(MEM_BYTES);
    localparam int unsigned MEM_LANES     = CPU_DW / MEM_DW;
    localparam int unsigned IO_LANES      = CPU_DW / IO_DW;
    localparam int unsigned IO_WORD_BEATS = WORD_BITS / IO_DW;

    logic          is_byte;
    logic          is_word;
    logic [AW-1:0] mem_base;

    assign is_byte = (size == SZ_BYTE);
    assign is_word = (size == SZ_WORD);

    always_comb begin
        // Byte accesses keep the full address; wider ones align to the bus word.
        mem_base = is_byte ? base_addr : (base_addr & ~AW'(MEM_BYTES - 1));
        mem_addr = mem_base + (AW'(beat) << MEM_SHIFT);
        io_addr  = base_addr + AW'(beat);
        mem_byte = is_byte;

        if (io_space) begin
            if (is_byte)      last = 1'b1;
            else if (is_word) last = (beat == BEAT_W'(IO_WORD_BEATS - 1));
            else              last = (beat == BEAT_W'(IO_LANES - 1));
        end else begin
            last = (is_byte || is_word) ? 1'b1 : (beat == BEAT_W'(MEM_LANES - 1));
        end

        // Memory: most significant word first.
        mem_wdata = '0;
        if (is_byte) begin
            mem_wdata[BYTE_BITS-1:0] = wdata[BYTE_BITS-1:0];
        end else if (is_word) begin
            mem_wdata = wdata[MEM_DW-1:0];
        end else begin
            for (int l = 0; l < int'(MEM_LANES); l++) begin
                if (int'(beat) == int'(MEM_LANES) - 1 - l)
                    mem_wdata = wdata[l*MEM_DW +: MEM_DW];
            end
        end

        // I/O: least significant byte first.
        io_wdata = '0;
        for (int l = 0; l < int'(IO_LANES); l++) begin
            if (int'(beat) == l)
                io_wdata = wdata[l*IO_DW +: IO_DW];
        end
    end

endmodule

// File: rtl/bseq_gather.sv
// Merges the data of one completed read beat into the result register.
module bseq_gather
    import bseq_pkg::*;
#(
    parameter int unsigned CPU_DW = 32,
    parameter int unsigned MEM_DW = 16,
    parameter int unsigned IO_DW  = 8,
    parameter int unsigned BEAT_W = 2
) (
    input  logic [CPU_DW-1:0] acc,
    input  logic [BEAT_W-1:0] beat,
    input  logic [1:0]        size,
    input  logic              io_space,
    input  logic [MEM_DW-1:0] mem_rd,
    input  logic [IO_DW-1:0]  io_rd,
    output logic [CPU_DW-1:0] acc_next
);
    localparam int unsigned MEM_LANES = CPU_DW / MEM_DW;
    localparam int unsigned IO_LANES  = CPU_DW / IO_DW;

    always_comb begin
        acc_next = acc;
        if (io_space) begin
            for (int l = 0; l < int'(IO_LANES); l++) begin
                if (int'(beat) == l)
                    acc_next[l*IO_DW +: IO_DW] = io_rd;
            end
        end else if (size == SZ_BYTE) begin
            acc_next = CPU_DW'(mem_rd[BYTE_BITS-1:0]);
        end else if (size == SZ_WORD) begin
            acc_next = CPU_DW'(mem_rd);
        end else begin
            for (int l = 0; l < int'(MEM_LANES); l++) begin
                if (int'(beat) == int'(MEM_LANES) - 1 - l)
                    acc_next[l*MEM_DW +: MEM_DW] = mem_rd;
            end
        end
    end

endmodule

// File: rtl/bus_split_seq.sv
module bus_split_seq
    import bseq_pkg::*;
#(
    parameter int unsigned AW     = 16,
    parameter int unsigned CPU_DW = 32,
    parameter int unsigned MEM_DW = 16,
    parameter int unsigned IO_DW  = 8,
    parameter int unsigned MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_space,
    input  logic [1:0]        req_size,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [CPU_DW-1:0] req_wdata,
    output logic              done,
    output logic [CPU_DW-1:0] rdata,
    output logic              mem_stb,
    output logic              mem_write,
    output logic              mem_byte,
    output logic [AW-1:0]     mem_addr,
    output logic [MEM_DW-1:0] mem_wdata,
    input  logic [MEM_DW-1:0] mem_rdata,
    input  logic              mem_rdy,
    output logic              io_stb,
    output logic              io_write,
    output logic [AW-1:0]     io_addr,
    output logic [IO_DW-1:0]  io_wdata,
    input  logic [IO_DW-1:0]  io_rdata,
    input  logic              io_rdy
);
    localparam int unsigned MAX_BEATS = CPU_DW / IO_DW;
    localparam int unsigned BEAT_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

    typedef struct packed {
        state_e              st;
        logic [BEAT_W-1:0]   beat;
        logic [AW-1:0]       addr;
        logic [1:0]          size;
        logic                io;
        logic                wr;
        logic [CPU_DW-1:0]   wdata;
        logic [CPU_DW-1:0]   acc;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic              beat_last;
    logic              beat_rdy;
    logic [CPU_DW-1:0] acc_next;

    bseq_plan #(
        .AW(AW), .CPU_DW(CPU_DW), .MEM_DW(MEM_DW), .IO_DW(IO_DW), .BEAT_W(BEAT_W)
    ) u_plan (
        .base_addr (ctx_q.addr),
        .size      (ctx_q.size),
        .io_space  (ctx_q.io),
        .beat      (ctx_q.beat),
        .wdata     (ctx_q.wdata),
        .mem_addr  (mem_addr),
        .io_addr   (io_addr),
        .mem_byte  (mem_byte),
        .last      (beat_last),
        .mem_wdata (mem_wdata),
        .io_wdata  (io_wdata)
    );

    bseq_gather #(
        .CPU_DW(CPU_DW), .MEM_DW(MEM_DW), .IO_DW(IO_DW), .BEAT_W(BEAT_W)
    ) u_gather (
        .acc      (ctx_q.acc),
        .beat     (ctx_q.beat),
        .size     (ctx_q.size),
        .io_space (ctx_q.io),
        .mem_rd   (mem_rdata),
        .io_rd    (io_rdata),
        .acc_next (acc_next)
    );

    assign beat_rdy = ctx_q.io ? io_rdy : mem_rdy;

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.addr  = req_addr;
                    ctx_d.size  = req_size;
                    ctx_d.io    = req_space;
                    ctx_d.wr    = req_write;
                    ctx_d.wdata = req_wdata;
                    ctx_d.acc   = '0;
                    ctx_d.beat  = '0;
                    // Special-space I/O has no bus here: complete with no cycle.
                    ctx_d.st    = (req_space && (req_mode != '0)) ? ST_DONE : ST_ISSUE;
                end
            end
            ST_ISSUE, ST_WAIT: begin
                if (beat_rdy) begin
                    if (!ctx_q.wr)
                        ctx_d.acc = acc_next;
                    if (beat_last) begin
                        ctx_d.st = ST_DONE;
                    end else begin
                        ctx_d.beat = ctx_q.beat + 1'b1;
                        ctx_d.st   = ST_ISSUE;
                    end
                end else begin
                    ctx_d.st = ST_WAIT;
                end
            end
            ST_DONE: ctx_d.st = ST_IDLE;
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign mem_stb   = (ctx_q.st == ST_ISSUE) && !ctx_q.io;
    assign io_stb    = (ctx_q.st == ST_ISSUE) &&  ctx_q.io;
    assign mem_write = mem_stb && ctx_q.wr;
    assign io_write  = io_stb  && ctx_q.wr;
    assign done      = (ctx_q.st == ST_DONE);
    assign rdata     = ctx_q.acc;

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_stb,
    input logic mem_rdy,
    input logic mem_byte,
    input logic mem_addr_lsb,
    input logic io_stb,
    input logic io_rdy,
    input logic done
);
    assert_one_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_stb && io_stb))
        else $error("both spaces strobed");

    assert_mem_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && !mem_rdy) |=> !mem_stb)
        else $error("memory strobe repeated before ready");

    assert_io_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_stb && !io_rdy) |=> !io_stb)
        else $error("I/O strobe repeated before ready");

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one clock");

    assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!mem_stb && !io_stb))
        else $error("strobe right after done");

    assert_word_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && !mem_byte) |-> !mem_addr_lsb)
        else $error("odd address on a word memory cycle");
endmodule

bind bus_split_seq bseq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_stb      (mem_stb),
    .mem_rdy      (mem_rdy),
    .mem_byte     (mem_byte),
    .mem_addr_lsb (mem_addr[0]),
    .io_stb       (io_stb),
    .io_rdy       (io_rdy),
    .done         (done)
);

// File: tb/sim_bus_split_seq.sv
`timescale 1ns/1ps
module sim_bus_split_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_space = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd0, req_mode = 2'd0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [31:0] rdata;
    logic        mem_stb, mem_write, mem_byte, io_stb, io_write;
    logic [15:0] mem_addr, mem_wdata, io_addr;
    logic [15:0] mem_rdata = '0;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata = '0;
    logic        mem_rdy = 1'b0, io_rdy = 1'b0;

    always #2 clk = ~clk;

    bus_split_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
        .req_size(req_size), .req_mode(req_mode), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .mem_stb(mem_stb), .mem_write(mem_write), .mem_byte(mem_byte),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rdy(mem_rdy), .io_stb(io_stb), .io_write(io_write), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rdy(io_rdy)
    );

    logic [7:0] bmem [0:65535];
    logic [7:0] bio  [0:65535];

    int n_chk = 0, n_fail = 0, ncyc = 0;
    int mem_lat = 0, io_lat = 0, viol = 0;
    int done_cnt = 0, done_cyc = 0, last_rdy_cyc = 0;
    bit mem_busy = 0, io_busy = 0;
    int mem_cnt = 0, io_cnt = 0;
    logic [15:0] mem_cap_addr = '0, io_cap_addr = '0;
    logic        mem_cap_byte = 1'b0;

    logic [15:0] ml_addr [8];
    logic [15:0] ml_data [8];
    logic        ml_byte [8];
    int          ml_n = 0;
    logic [15:0] il_addr [8];
    logic [7:0]  il_data [8];
    int          il_n = 0;

    // Bus models, sampled away from the active edge.
    always @(negedge clk) begin
        ncyc = ncyc + 1;
        mem_rdy = 1'b0;
        io_rdy  = 1'b0;
        if (done) begin
            done_cnt = done_cnt + 1;
            done_cyc = ncyc;
        end
        if (mem_stb) begin
            if (mem_busy) viol = viol + 1;
            mem_busy = 1; mem_cnt = mem_lat;
            mem_cap_addr = mem_addr; mem_cap_byte = mem_byte;
            if (ml_n < 8) begin
                ml_addr[ml_n] = mem_addr; ml_data[ml_n] = mem_wdata; ml_byte[ml_n] = mem_byte;
            end
            ml_n = ml_n + 1;
            if (mem_write) begin
                if (mem_byte) bmem[mem_addr] = mem_wdata[7:0];
                else begin
                    bmem[mem_addr] = mem_wdata[15:8];
                    bmem[mem_addr + 16'd1] = mem_wdata[7:0];
                end
            end
        end
        if (mem_busy) begin
            if (mem_cnt == 0) begin
                mem_rdy = 1'b1; mem_busy = 0; last_rdy_cyc = ncyc;
                if (mem_cap_byte) mem_rdata = {8'h00, bmem[mem_cap_addr]};
                else mem_rdata = {bmem[mem_cap_addr], bmem[mem_cap_addr + 16'd1]};
            end else mem_cnt = mem_cnt - 1;
        end
        if (io_stb) begin
            if (io_busy) viol = viol + 1;
            io_busy = 1; io_cnt = io_lat; io_cap_addr = io_addr;
            if (il_n < 8) begin
                il_addr[il_n] = io_addr; il_data[il_n] = io_wdata;
            end
            il_n = il_n + 1;
            if (io_write) bio[io_addr] = io_wdata;
        end
        if (io_busy) begin
            if (io_cnt == 0) begin
                io_rdy = 1'b1; io_busy = 0; last_rdy_cyc = ncyc;
                io_rdata = bio[io_cap_addr];
            end else io_cnt = io_cnt - 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic start_req(input bit io, input logic [1:0] sz, input logic [15:0] a,
                             input bit wr, input logic [31:0] wd, input logic [1:0] md);
        @(negedge clk);
        ml_n = 0; il_n = 0; done_cnt = 0;
        req_valid = 1'b1; req_space = io; req_size = sz; req_addr = a;
        req_write = wr; req_wdata = wd; req_mode = md;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output logic [31:0] res);
        int t = 0;
        while (!done && t < 100) begin
            @(negedge clk);
            t++;
        end
        chk("R7 done seen", 32'(done), 32'd1);
        res = rdata;
        @(negedge clk);
        chk("R7 done single clock", 32'(done), 32'd0);
    endtask

    task automatic access(input bit io, input logic [1:0] sz, input logic [15:0] a,
                          input bit wr, input logic [31:0] wd, input logic [1:0] md,
                          output logic [31:0] res);
        start_req(io, sz, a, wr, wd, md);
        wait_done(res);
    endtask

    task automatic t_reset();
        chk("R9 done low", 32'(done), 32'd0);
        chk("R9 mem_stb low", 32'(mem_stb), 32'd0);
        chk("R9 io_stb low", 32'(io_stb), 32'd0);
        chk("R9 rdata zero", rdata, 32'd0);
    endtask

    task automatic t_mem_word();
        logic [31:0] r;
        bmem[16'h0120] = 8'hAB; bmem[16'h0121] = 8'hCD;
        access(0, 2'd1, 16'h0121, 0, 0, 2'd0, r);
        chk("R1 word read aligned addr", 32'(ml_addr[0]), 32'h0120);
        chk("R1 word read one cycle", ml_n, 1);
        chk("R10 word zero-extended", r, 32'h0000ABCD);
        access(0, 2'd1, 16'h0131, 1, 32'hFFFF1234, 2'd0, r);
        chk("R1 word write aligned addr", 32'(ml_addr[0]), 32'h0130);
        chk("R1 word write high byte", 32'(bmem[16'h0130]), 32'h12);
        chk("R1 word write low byte", 32'(bmem[16'h0131]), 32'h34);
    endtask

    task automatic t_mem_byte();
        logic [31:0] r;
        access(0, 2'd0, 16'h0121, 0, 0, 2'd0, r);
        chk("R1 byte keeps odd addr", 32'(ml_addr[0]), 32'h0121);
        chk("R10 byte flag", 32'(ml_byte[0]), 32'd1);
        chk("R10 byte zero-extended", r, 32'h000000CD);
        bmem[16'h0140] = 8'h77; bmem[16'h0141] = 8'h00;
        access(0, 2'd0, 16'h0141, 1, 32'h1234565A, 2'd0, r);
        chk("R10 byte write value", 32'(bmem[16'h0141]), 32'h5A);
        chk("R10 byte write neighbour kept", 32'(bmem[16'h0140]), 32'h77);
    endtask

    task automatic t_mem_long();
        logic [31:0] r;
        bmem[16'h0200] = 8'h11; bmem[16'h0201] = 8'h22;
        bmem[16'h0202] = 8'h33; bmem[16'h0203] = 8'h44;
        access(0, 2'd2, 16'h0201, 0, 0, 2'd0, r);
        chk("R2 long two cycles", ml_n, 2);
        chk("R2 long first addr", 32'(ml_addr[0]), 32'h0200);
        chk("R2 long second addr", 32'(ml_addr[1]), 32'h0202);
        chk("R2 long read value", r, 32'h11223344);
        access(0, 2'd2, 16'h0300, 1, 32'hA1B2C3D4, 2'd0, r);
        chk("R2 long write first word", 32'(ml_data[0]), 32'hA1B2);
        chk("R2 long write second word", 32'(ml_data[1]), 32'hC3D4);
        chk("R2 long write memory", {bmem[16'h0300], bmem[16'h0301], bmem[16'h0302], bmem[16'h0303]},
            32'hA1B2C3D4);
    endtask

    task automatic t_io_word();
        logic [31:0] r;
        bio[16'h0041] = 8'h5E; bio[16'h0042] = 8'h7F;
        access(1, 2'd1, 16'h0041, 0, 0, 2'd0, r);
        chk("R3 io word two cycles", il_n, 2);
        chk("R3 io word first addr", 32'(il_addr[0]), 32'h0041);
        chk("R3 io word second addr", 32'(il_addr[1]), 32'h0042);
        chk("R3 io word read value", r, 32'h00007F5E);
        access(1, 2'd1, 16'h0050, 1, 32'h0000BEEF, 2'd0, r);
        chk("R3 io word low byte first", 32'(il_data[0]), 32'hEF);
        chk("R3 io word high byte second", 32'(il_data[1]), 32'hBE);
        chk("R3 io word stored", {bio[16'h0051], bio[16'h0050]}, 32'h0000BEEF);
    endtask

    task automatic t_io_long();
        logic [31:0] r;
        bio[16'h0060] = 8'h01; bio[16'h0061] = 8'h02;
        bio[16'h0062] = 8'h03; bio[16'h0063] = 8'h04;
        access(1, 2'd2, 16'h0060, 0, 0, 2'd0, r);
        chk("R4 io long four cycles", il_n, 4);
        for (int k = 0; k < 4; k++)
            chk("R4 io long addr order", 32'(il_addr[k]), 32'h0060 + k);
        chk("R4 io long read value", r, 32'h04030201);
        access(1, 2'd2, 16'h0070, 1, 32'h8899AABB, 2'd0, r);
        chk("R4 io long byte 0", 32'(il_data[0]), 32'hBB);
        chk("R4 io long byte 1", 32'(il_data[1]), 32'hAA);
        chk("R4 io long byte 2", 32'(il_data[2]), 32'h99);
        chk("R4 io long byte 3", 32'(il_data[3]), 32'h88);
    endtask

    task automatic t_special();
        logic [31:0] r;
        access(1, 2'd2, 16'h0060, 0, 0, 2'd0, r);
        access(1, 2'd2, 16'h0060, 0, 0, 2'd1, r);
        chk("R5 special read zero", r, 32'd0);
        chk("R5 special read no io cycle", il_n, 0);
        chk("R5 special read no mem cycle", ml_n, 0);
        bio[16'h0080] = 8'h33;
        access(1, 2'd0, 16'h0080, 1, 32'h000000EE, 2'd3, r);
        chk("R5 special write no io cycle", il_n, 0);
        chk("R5 special write space unchanged", 32'(bio[16'h0080]), 32'h33);
        access(0, 2'd1, 16'h0120, 0, 0, 2'd2, r);
        chk("R5 memory ignores mode", r, 32'h0000ABCD);
        chk("R5 memory ignores mode cycle", ml_n, 1);
    endtask

    task automatic t_wait();
        logic [31:0] r;
        mem_lat = 3; io_lat = 2; viol = 0;
        access(0, 2'd2, 16'h0200, 0, 0, 2'd0, r);
        chk("R6 mem long with wait", r, 32'h11223344);
        chk("R7 done right after last ready (mem)", done_cyc, last_rdy_cyc + 1);
        access(1, 2'd2, 16'h0060, 0, 0, 2'd0, r);
        chk("R6 io long with wait", r, 32'h04030201);
        chk("R7 done right after last ready (io)", done_cyc, last_rdy_cyc + 1);
        chk("R6 no strobe before ready", viol, 0);
        mem_lat = 0; io_lat = 0;
    endtask

    task automatic t_overlap();
        logic [31:0] r;
        mem_lat = 2;
        bio[16'h0090] = 8'h44;
        start_req(0, 2'd2, 16'h0200, 0, 0, 2'd0);
        @(negedge clk);
        req_valid = 1'b1; req_space = 1'b1; req_size = 2'd0; req_addr = 16'h0090;
        req_write = 1'b1; req_wdata = 32'h000000CC; req_mode = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(r);
        chk("R8 ongoing read intact", r, 32'h11223344);
        chk("R8 no io cycle from dropped request", il_n, 0);
        repeat (6) @(negedge clk);
        chk("R8 io space untouched", 32'(bio[16'h0090]), 32'h44);
        chk("R8 single done", done_cnt, 1);
        mem_lat = 0;
    endtask

    initial begin
        for (int i = 0; i < 65536; i++) begin
            bmem[i] = 8'h00; bio[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mem_word();
        t_mem_byte();
        t_mem_long();
        t_io_word();
        t_io_long();
        t_special();
        t_wait();
        t_overlap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule